// File: doc/BRIEF.md
# Bus Clock Stop Gating Controller

This block gates a group of slow bus clock outputs and one fast differential clock pair when an active-low stop request is raised. The stop request comes from either a device pin or a control bit. It is synchronized into the free-running slow clock domain. Every stoppable slow output is then parked low on its next falling edge. Only after that does a handshake flag reach the fast domain, and the fast pair parks with its true leg high and its complement leg low. If a select bit asks for it, the pair is released to high impedance instead.

Seven plain slow outputs are always stoppable. Three flexible slow outputs can each be set to free-run, and a free-running output ignores both stop sources. The fast pair has its own free-run select. Every output has an enable bit, and a disabled output is held low. When the request is withdrawn, the outputs restart on their next safe edge without short pulses.

Top module: `bus_clk_stop_gate`

## Requirements
- R1: A change of the stop request is taken on rising edges of `clk_slow` through two flops. A stoppable slow output still pulses in the second high phase after the change. From the third high phase on, it is parked.
- R2: A stoppable slow output parks low. Its gate changes only on a falling edge of `clk_slow`, so no high or low pulse on it is shorter than half a slow period.
- R3: A stoppable fast pair parks with `fast_t_o` high and `fast_c_o` low. Its first parked low phase comes strictly after the last high pulse of the slow outputs.
- R4: While the fast pair is parked and `fast_tristate` is 1, `fast_oe_o` is 0. At all other times it is 1.
- R5: A flexible output whose `flex_stoppable` bit is 0 keeps toggling under either stop source. With the bit at 1, it stops like a plain output. Plain outputs are always stoppable.
- R6: `stop_reg_n` = 0 stops the outputs exactly as `stop_pin_n` = 0 does. The effective request is the OR of the two.
- R7: With `fast_stoppable` = 0, the fast pair keeps toggling during a stop: true low and complement high in the low phase of `clk_fast`.
- R8: An output whose enable bit is 0 is held low. For the fast pair, both legs are held low.
- R9: After the request is withdrawn, the slow outputs run again from the third high phase, the fast pair follows, and no short pulse appears.
- R10: After reset, no output is stopped: all enabled outputs toggle and `fast_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Free-running slow bus clock |
| clk_fast | input | 1 | Fast clock for the differential pair |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Stop pin, active low |
| stop_reg_n | input | 1 | Stop control bit, 0 requests a stop |
| flex_stoppable | input | NF | Per flexible output: 1 stoppable, 0 free-run |
| plain_en | input | NP | Enables for the plain slow outputs |
| flex_en | input | NF | Enables for the flexible slow outputs |
| fast_en | input | 1 | Enable for the fast pair |
| fast_stoppable | input | 1 | 1 lets the fast pair stop |
| fast_tristate | input | 1 | 1 floats the pair instead of parking it |
| plain_clk_o | output | NP | Gated plain slow clocks |
| flex_clk_o | output | NF | Gated flexible slow clocks |
| fast_t_o | output | 1 | Fast true output |
| fast_c_o | output | 1 | Fast complement output |
| fast_oe_o | output | 1 | Output enable of the fast pair |

## Verification
The assertions assume that both clocks run without interruption. They also assume the free-run selects are steady for at least one slow cycle before a check uses them, and that the enables are quasi-static configuration. The glitch and ordering monitors are only armed while the enables and selects are held fixed. The random phase changes the configuration only just after a falling edge of the slow clock. It then lets several slow cycles pass before it samples, so every synchronizer and handshake has settled.

// File: rtl/bus_clk_stop_gate.sv
module bus_clk_stop_gate #(
  parameter int NP = 7,
  parameter int NF = 3
) (
  input  logic          clk_slow,
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic          stop_pin_n,
  input  logic          stop_reg_n,
  input  logic [NF-1:0] flex_stoppable,
  input  logic [NP-1:0] plain_en,
  input  logic [NF-1:0] flex_en,
  input  logic          fast_en,
  input  logic          fast_stoppable,
  input  logic          fast_tristate,
  output logic [NP-1:0] plain_clk_o,
  output logic [NF-1:0] flex_clk_o,
  output logic          fast_t_o,
  output logic          fast_c_o,
  output logic          fast_oe_o
);

  logic          req;
  logic          s1, s2, stop_slow;
  logic [NF-1:0] flex_run;
  logic          f1, f2, stop_fast;

  assign req = ~stop_pin_n | ~stop_reg_n;

  // request synchronizer, slow clock rising edge
  always_ff @(posedge clk_slow or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= req;
      s2 <= s1;
    end

  // slow gates move only while the slow clock is low
  always_ff @(negedge clk_slow or negedge rst_n)
    if (!rst_n) begin
      stop_slow <= 1'b0;
      flex_run  <= '1;
    end else begin
      stop_slow <= s2;
      flex_run  <= ~({NF{s2}} & flex_stoppable);
    end

  assign plain_clk_o = {NP{clk_slow & ~stop_slow}} & plain_en;
  assign flex_clk_o  = {NF{clk_slow}} & flex_run & flex_en;

  // parked flag crosses into the fast domain; fast gate moves while clk_fast is high
  always_ff @(posedge clk_fast or negedge rst_n)
    if (!rst_n) begin
      f1        <= 1'b0;
      f2        <= 1'b0;
      stop_fast <= 1'b0;
    end else begin
      f1        <= stop_slow;
      f2        <= f1;
      stop_fast <= f2 & fast_stoppable;
    end

  assign fast_t_o  = (clk_fast | stop_fast) & fast_en;
  assign fast_c_o  = ~clk_fast & ~stop_fast & fast_en;
  assign fast_oe_o = ~(stop_fast & fast_tristate);

  assert_slow_held_R2: assert property (@(negedge clk_slow) disable iff (!rst_n)
    (stop_slow && $past(stop_slow)) |-> (plain_clk_o == '0 && $stable(plain_clk_o)));

  assert_disabled_low_R8: assert property (@(negedge clk_slow) disable iff (!rst_n)
    ((plain_clk_o & ~plain_en) == '0) && ((flex_clk_o & ~flex_en) == '0));

  assert_fast_held_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (stop_fast && $past(stop_fast) && fast_en && $past(fast_en))
      |-> (fast_t_o && !fast_c_o && $stable(fast_t_o)));

  assert_tristate_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (stop_fast && fast_tristate) |-> !fast_oe_o);

  assert_fast_off_R8: assert property (@(negedge clk_fast) disable iff (!rst_n)
    !fast_en |-> (!fast_t_o && !fast_c_o));

  for (genvar i = 0; i < NF; i++) begin : g_flex_chk
    assert_freerun_R5: assert property (@(negedge clk_slow) disable iff (!rst_n)
      (!flex_stoppable[i] && $past(!flex_stoppable[i]) && flex_en[i]) |-> flex_clk_o[i]);
  end

endmodule

// File: tb/bus_clk_stop_gate_tb.sv
`timescale 1ns/1ps
module bus_clk_stop_gate_tb;
  localparam int NP = 7;
  localparam int NF = 3;

  logic clk_slow = 0, clk_fast = 0, rst_n = 0;
  logic stop_pin_n = 1, stop_reg_n = 1;
  logic [NF-1:0] flex_stoppable = '0, flex_en = '1;
  logic [NP-1:0] plain_en = '1;
  logic fast_en = 1, fast_stoppable = 1, fast_tristate = 0;
  logic [NP-1:0] plain_clk_o;
  logic [NF-1:0] flex_clk_o;
  logic fast_t_o, fast_c_o, fast_oe_o;

  int errors = 0, checks = 0, glitches = 0;
  bit mon_on = 0;
  realtime t_r, t_f, tf_r, tf_f, t_slow_hi, fast_park_t;

  always #4  clk_fast = ~clk_fast;
  always #12 clk_slow = ~clk_slow;

  bus_clk_stop_gate #(.NP(NP), .NF(NF)) u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic slow_hi(); @(posedge clk_slow); #2; endtask
  task automatic fast_lo(); @(negedge clk_fast); #2; endtask
  task automatic slot();    @(negedge clk_slow); #1; endtask

  // pulse width monitors (R2, R9)
  always @(posedge plain_clk_o[0]) begin
    if (mon_on && $realtime - t_f < 11.0) glitches++;
    t_r = $realtime;
  end
  always @(negedge plain_clk_o[0]) begin
    if (mon_on && $realtime - t_r < 11.0) glitches++;
    t_f = $realtime;
  end
  always @(posedge fast_t_o) begin
    if (mon_on && $realtime - tf_f < 3.5) glitches++;
    tf_r = $realtime;
  end
  always @(negedge fast_t_o) begin
    if (mon_on && $realtime - tf_r < 3.5) glitches++;
    tf_f = $realtime;
  end
  // ordering monitors (R3)
  always @(posedge clk_slow) begin #2; if (plain_clk_o[0]) t_slow_hi = $realtime; end
  always @(negedge clk_fast) begin #2; if (fast_t_o && fast_park_t == 0) fast_park_t = $realtime; end

  function automatic logic [NP-1:0] e_plain(logic st, logic [NP-1:0] en);
    return st ? '0 : en;
  endfunction
  function automatic logic [NF-1:0] e_flex(logic st, logic [NF-1:0] s, logic [NF-1:0] en);
    return en & ~(st ? s : '0);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    t_r = 0; t_f = 0; tf_r = 0; tf_f = 0; t_slow_hi = 0; fast_park_t = 0;
    #30 rst_n = 1;
    repeat (3) slow_hi();
    chk("R10 plain", 16'(plain_clk_o), 16'(7'h7f));
    chk("R10 flex", 16'(flex_clk_o), 16'(3'h7));
    fast_lo();
    chk("R10 fast", {13'd0, fast_t_o, fast_c_o, fast_oe_o}, 16'b011);

    slot(); flex_stoppable = 3'b011;
    repeat (3) slow_hi();
    mon_on = 1; fast_park_t = 0;
    slot(); stop_pin_n = 0;
    slow_hi(); slow_hi();
    chk("R1 still running", 16'(plain_clk_o), 16'(7'h7f));
    slow_hi();
    chk("R1 parked", 16'(plain_clk_o), 16'(0));
    chk("R5 free-run flex", 16'(flex_clk_o), 16'(3'b100));
    repeat (3) slow_hi();
    fast_lo();
    chk("R3 fast park", {14'd0, fast_t_o, fast_c_o}, 16'b10);
    chk("R4 oe parked", 16'(fast_oe_o), 16'(1));
    chk("R3 order", 16'(fast_park_t > t_slow_hi && fast_park_t != 0), 16'(1));

    slot(); fast_tristate = 1;
    slow_hi(); fast_lo();
    chk("R4 tristate", 16'(fast_oe_o), 16'(0));
    slot(); fast_tristate = 0;

    slot(); stop_pin_n = 1;
    slow_hi(); slow_hi();
    chk("R9 still parked", 16'(plain_clk_o), 16'(0));
    slow_hi();
    chk("R9 resumed", 16'(plain_clk_o), 16'(7'h7f));
    chk("R9 flex resumed", 16'(flex_clk_o), 16'(3'h7));
    repeat (2) slow_hi();
    fast_lo();
    chk("R9 fast resumed", {13'd0, fast_t_o, fast_c_o, fast_oe_o}, 16'b011);

    slot(); stop_reg_n = 0;
    repeat (3) slow_hi();
    chk("R6 reg stop", 16'(plain_clk_o), 16'(0));
    chk("R6 flex free-run", 16'(flex_clk_o), 16'(3'b100));
    repeat (3) slow_hi();
    fast_lo();
    chk("R6 fast park", {14'd0, fast_t_o, fast_c_o}, 16'b10);
    slot(); stop_reg_n = 1;
    repeat (4) slow_hi();
    chk("R2 R9 glitch count", 16'(glitches), 16'(0));
    mon_on = 0;

    slot(); plain_en = 7'b1110111; fast_en = 0;
    slow_hi();
    chk("R8 plain disabled", 16'(plain_clk_o), 16'(7'b1110111));
    fast_lo();
    chk("R8 fast disabled", {14'd0, fast_t_o, fast_c_o}, 16'b00);
    slot(); plain_en = '1; fast_en = 1; fast_stoppable = 0; stop_pin_n = 0;
    repeat (6) slow_hi();
    fast_lo();
    chk("R7 fast free-run", {13'd0, fast_t_o, fast_c_o, fast_oe_o}, 16'b011);
    slot(); stop_pin_n = 1; fast_stoppable = 1;
    repeat (4) slow_hi();

    for (int k = 0; k < 40; k++) begin
      logic st, ps;
      slot();
      stop_pin_n     = ($urandom % 3) != 0;
      stop_reg_n     = ($urandom % 3) != 0;
      flex_stoppable = NF'($urandom);
      plain_en       = NP'($urandom) | NP'($urandom);
      flex_en        = NF'($urandom) | NF'($urandom);
      fast_en        = ($urandom % 4) != 0;
      fast_stoppable = ($urandom % 3) != 0;
      fast_tristate  = $urandom % 2;
      st = !stop_pin_n || !stop_reg_n;
      ps = st && fast_stoppable;
      repeat (8) slow_hi();
      chk(st ? "R1 R6 random plain" : "R9 random plain", 16'(plain_clk_o), 16'(e_plain(st, plain_en)));
      chk("R5 R8 random flex", 16'(flex_clk_o), 16'(e_flex(st, flex_stoppable, flex_en)));
      fast_lo();
      chk("R3 R7 R8 random fast", {14'd0, fast_t_o, fast_c_o},
          {14'd0, fast_en & ps, fast_en & !ps});
      chk("R4 random oe", 16'(fast_oe_o), 16'(!(ps && fast_tristate)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule